// File: doc/BRIEF.md
# Iterative Bitsliced 128-bit Block Encryption Core

This core encrypts one 128-bit block at a time and runs one cipher round per clock. The block is held as four 32-bit words. Each round XORs in a 128-bit round key and passes all 32 bit columns through one of eight 4-bit substitution boxes at once. Every round except the last then applies a fixed word-mixing step built from rotates, zero-fill shifts and XORs. The round keys come from outside the core. The core puts the number of the key it needs on `key_idx`, and the surrounding logic returns that key on `round_key` in the same cycle, without a register in between. Key expansion happens outside the core.

A block enters through a valid/ready handshake and is taken on the edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a block is being processed, so the handshake is the only way the producer is held off. The result leaves without back-pressure. `out_valid` pulses for exactly one cycle. `out_block` keeps the ciphertext until the next block is accepted, so a consumer that misses the pulse can still read the result. A new block may be offered in the same cycle as the `out_valid` pulse.

Top module: `serpent_iter_core`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `key_idx` is 0 and `out_block` is all zeros.
- R2: A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 for exactly 33 cycles and returns to 1 in the same cycle that `out_valid` rises.
- R3: While `in_ready` is 0, `in_valid` and `in_block` have no effect. The ciphertext of the block already in flight is unchanged.
- R4: `key_idx` is 0 in the cycle after acceptance and increases by one every cycle until it reaches 32. Key k is used in the cycle where `key_idx` equals k.
- R5: Key mixing XORs word i of the round key into word i of the state. Word i of any 128-bit port is bits [32i+31:32i].
- R6: Round r (0..31) uses substitution box r mod 8. Each box is listed as its outputs for inputs 0 to 15. Box 0: 3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12. Box 1: 15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4. Box 2: 8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2. Box 3: 0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14. Box 4: 1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13. Box 5: 15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1. Box 6: 7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0. Box 7: 1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6.
- R7: For each bit column j, the box input is {w3[j],w2[j],w1[j],w0[j]} with w0 as the LSB. Output bit k goes back to bit j of word k.
- R8: The mixing step after rounds 0..30 runs in this order. Rotate w0 left by 13 and w2 left by 3. Set w1 = w1^w0^w2 and w3 = w3^w2^(w0<<3). Rotate w1 left by 1 and w3 left by 7. Set w0 = w0^w1^w3 and w2 = w2^w3^(w1<<7). Rotate w0 left by 5 and w2 left by 22. The `<<` shifts fill with zeros.
- R9: Round 31 skips the mixing step. Instead, key 32 is XORed into the state, so one block uses 33 keys.
- R10: `out_valid` is high for exactly one cycle, 33 cycles after acceptance. `out_block` then holds the ciphertext unchanged until the next block is accepted.
- R11: A block offered during the `out_valid` cycle is accepted at once and is encrypted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Plaintext offered |
| in_ready | output | 1 | Core idle and able to take a block |
| in_block | input | 128 | Plaintext, word i in bits [32i+31:32i] |
| key_idx | output | 6 | Number of the round key needed this cycle |
| round_key | input | 128 | Round key selected by `key_idx`, same word layout |
| out_valid | output | 1 | One-cycle pulse when the ciphertext is ready |
| out_block | output | 128 | Ciphertext, held until the next accept |

## Verification
The hardest case to reach from the ports is a block offered while another is in flight. The stimulus raises `in_valid` with a different plaintext partway through an encryption. It then checks that `in_ready` stayed low and that the result still matches the first plaintext. A second hard case is the hand-over in the `out_valid` cycle itself. The bench offers the next block on that same cycle and checks both ciphertexts. `key_idx` is traced on every cycle of a run, so a skipped or repeated key shows up even when the final data would hide it.

// File: rtl/serpent_pkg.sv
package serpent_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 4;
  localparam int N_BOXES = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

  // Each box packed as 16 nibbles, entry for input n in bits [4n+3:4n].
  localparam logic [N_BOXES-1:0][63:0] SBOX_TABLE = {
    64'h6539AC47B28E0FD1,  // box 7
    64'h0A3DF19EB6485C27,  // box 6
    64'h176D8E30C9A4B25F,  // box 5
    64'hD7E9A4526B0C38F1,  // box 4
    64'hE57A421D369C8BF0,  // box 3
    64'h25B04E1DFAC39768,  // box 2
    64'h43D68EB1A50972CF,  // box 1
    64'hC90724DEB56A1F83   // box 0
  };

  function automatic word_t rotl(input word_t v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/sbox_word.sv
// One 4-in/4-out substitution applied to all bit columns of four words,
// built as a sum of minterms over whole words.
module sbox_word
  import serpent_pkg::*;
#(
  parameter logic [63:0] TABLE = 64'h0
) (
  input  state_t din,
  output state_t dout
);
  always_comb begin
    dout = '0;
    for (int m = 0; m < 16; m++) begin
      logic [3:0] code;
      word_t      hit;
      code = 4'(m);
      hit  = '1;
      for (int b = 0; b < N_WORDS; b++)
        hit &= code[b] ? din[b] : ~din[b];
      for (int o = 0; o < N_WORDS; o++)
        if (TABLE[4*m+o]) dout[o] |= hit;
    end
  end
endmodule

// File: rtl/sbox_bank.sv
module sbox_bank
  import serpent_pkg::*;
#(
  parameter int SEL_W = $clog2(N_BOXES)
) (
  input  logic [SEL_W-1:0] sel,
  input  state_t           din,
  output state_t           dout
);
  state_t box_out [N_BOXES];

  for (genvar g = 0; g < N_BOXES; g++) begin : g_box
    sbox_word #(.TABLE(SBOX_TABLE[g])) u_box (
      .din  (din),
      .dout (box_out[g])
    );
  end

  assign dout = box_out[sel];
endmodule

// File: rtl/mix_layer.sv
module mix_layer
  import serpent_pkg::*;
(
  input  state_t din,
  output state_t dout
);
  always_comb begin
    word_t p0, p1, p2, p3;
    p0 = rotl(din[0], 13);
    p2 = rotl(din[2], 3);
    p1 = rotl(din[1] ^ p0 ^ p2, 1);
    p3 = rotl(din[3] ^ p2 ^ (p0 << 3), 7);
    dout[0] = rotl(p0 ^ p1 ^ p3, 5);
    dout[2] = rotl(p2 ^ p3 ^ (p1 << 7), 22);
    dout[1] = p1;
    dout[3] = p3;
  end
endmodule

// File: rtl/serpent_iter_core.sv
module serpent_iter_core
  import serpent_pkg::*;
#(
  parameter int NUM_ROUNDS = 32,
  localparam int KIDX_W = $clog2(NUM_ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [127:0]      in_block,
  output logic [KIDX_W-1:0] key_idx,
  input  logic [127:0]      round_key,
  output logic              out_valid,
  output logic [127:0]      out_block
);
  localparam logic [KIDX_W-1:0] FINAL_IDX = KIDX_W'(NUM_ROUNDS);
  localparam logic [KIDX_W-1:0] LAST_RND  = KIDX_W'(NUM_ROUNDS - 1);
  localparam int SEL_W = $clog2(N_BOXES);

  state_t            st, keyed, subbed, mixed, nxt;
  logic [KIDX_W-1:0] rnd;
  logic              busy, done;

  assign keyed = st ^ state_t'(round_key);

  sbox_bank #(.SEL_W(SEL_W)) u_bank (
    .sel  (rnd[SEL_W-1:0]),
    .din  (keyed),
    .dout (subbed)
  );

  mix_layer u_mix (
    .din  (subbed),
    .dout (mixed)
  );

  always_comb begin
    if (rnd == FINAL_IDX)     nxt = keyed;
    else if (rnd == LAST_RND) nxt = subbed;
    else                      nxt = mixed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= '0;
      rnd  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (in_valid) begin
          st   <= state_t'(in_block);
          rnd  <= '0;
          busy <= 1'b1;
        end
      end else begin
        st <= nxt;
        if (rnd == FINAL_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
          rnd  <= '0;
        end else begin
          rnd <= rnd + 1'b1;
        end
      end
    end
  end

  assign in_ready  = !busy;
  assign key_idx   = rnd;
  assign out_valid = done;
  assign out_block = 128'(st);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r4_first_key: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (key_idx == '0 && !in_ready));
  a_r4_key_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && key_idx != FINAL_IDX) |=> (key_idx == $past(key_idx) + 1'b1));
  a_r2_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && key_idx == FINAL_IDX) |=> (out_valid && in_ready));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_block));
endmodule

// File: tb/serpent_iter_core_test.sv
module serpent_iter_core_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic [127:0] in_block = '0;
  logic [5:0]   key_idx;
  logic [127:0] round_key;
  logic         in_ready, out_valid;
  logic [127:0] out_block;
  logic [127:0] keys [0:32];
  int n_total = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign round_key = (key_idx <= 6'd32) ? keys[key_idx] : '0;

  serpent_iter_core uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .key_idx(key_idx), .round_key(round_key),
    .out_valid(out_valid), .out_block(out_block)
  );

  int box [8][16] = '{
    '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12},
    '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4},
    '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2},
    '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14},
    '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13},
    '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1},
    '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0},
    '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6}
  };

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return {v, v} >> (32 - n);
  endfunction

  function automatic logic [127:0] model(input logic [127:0] pt);
    logic [31:0] w [4];
    logic [31:0] s [4];
    for (int i = 0; i < 4; i++) w[i] = pt[32*i +: 32];
    for (int r = 0; r < 32; r++) begin
      for (int i = 0; i < 4; i++) w[i] ^= keys[r][32*i +: 32];
      for (int j = 0; j < 32; j++) begin
        int n, v;
        n = {28'd0, w[3][j], w[2][j], w[1][j], w[0][j]};
        v = box[r % 8][n];
        for (int k = 0; k < 4; k++) s[k][j] = v[k];
      end
      if (r == 31) begin
        for (int i = 0; i < 4; i++) w[i] = s[i] ^ keys[32][32*i +: 32];
      end else begin
        s[0] = rl(s[0], 13);
        s[2] = rl(s[2], 3);
        s[1] = s[1] ^ s[0] ^ s[2];
        s[3] = s[3] ^ s[2] ^ (s[0] << 3);
        s[1] = rl(s[1], 1);
        s[3] = rl(s[3], 7);
        s[0] = s[0] ^ s[1] ^ s[3];
        s[2] = s[2] ^ s[3] ^ (s[1] << 7);
        s[0] = rl(s[0], 5);
        s[2] = rl(s[2], 22);
        for (int i = 0; i < 4; i++) w[i] = s[i];
      end
    end
    return {w[3], w[2], w[1], w[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  task automatic set_keys(input logic [31:0] seed, input bit zero);
    logic [31:0] s = seed;
    for (int i = 0; i <= 32; i++) begin
      for (int k = 0; k < 4; k++) begin
        s = s * 32'd1664525 + 32'd1013904223;
        keys[i][32*k +: 32] = zero ? 32'd0 : s;
      end
    end
  endtask

  // Offers pt at the current negedge, optionally pokes a second block while busy,
  // and returns at the negedge where out_valid is seen.
  task automatic run_block(input logic [127:0] pt, input int poke_at,
                           input logic [127:0] poke_pt, input string tag);
    int cnt = 0;
    bit seq_ok = 1, rdy_ok = 1;
    logic [127:0] exp;
    exp = model(pt);
    in_valid = 1; in_block = pt;
    @(negedge clk);
    in_valid = 0; in_block = '0;
    if (key_idx != 0 || in_ready) seq_ok = 0;
    while (cnt < 40) begin
      if (cnt == poke_at) begin in_valid = 1; in_block = poke_pt; end
      @(negedge clk);
      in_valid = 0;
      cnt++;
      if (out_valid) break;
      if (key_idx != 6'(cnt)) seq_ok = 0;
      if (in_ready) rdy_ok = 0;
    end
    chk(seq_ok, {"R4 key index sequence ", tag}, 128'(key_idx), 128'(cnt));
    chk(rdy_ok && in_ready, {"R2 in_ready low while busy ", tag}, 128'(in_ready), 128'd1);
    chk(cnt == 33, {"R10 latency ", tag}, 128'(cnt), 128'd33);
    chk(out_block === exp, {"R5 R6 R7 R8 R9 ciphertext ", tag}, out_block, exp);
  endtask

  task automatic t_reset();
    chk(in_ready === 1'b1, "R1 in_ready", 128'(in_ready), 128'd1);
    chk(out_valid === 1'b0, "R1 out_valid", 128'(out_valid), 128'd0);
    chk(key_idx === 6'd0, "R1 key_idx", 128'(key_idx), 128'd0);
    chk(out_block === '0, "R1 out_block", out_block, '0);
  endtask

  task automatic t_patterns();
    set_keys(32'h0, 1);
    run_block('0, -1, '0, "zero key zero block");
    run_block(128'h1, -1, '0, "zero key single bit");
    set_keys(32'h1234_5678, 0);
    run_block('0, -1, '0, "zero block");
    run_block('1, -1, '0, "ones");
    run_block({4{32'hA5A5_5A5A}}, -1, '0, "alternating");
    run_block(128'h00112233_44556677_8899AABB_CCDDEEFF, -1, '0, "ascending");
  endtask

  task automatic t_word_order();
    set_keys(32'h0, 1);
    keys[0] = {32'h0, 32'hDEADBEEF, 32'h0, 32'h0};
    keys[32] = {32'h0, 32'h0, 32'h0, 32'h0F0F_F0F0};
    run_block(128'h0, -1, '0, "R5 single word keys");
  endtask

  task automatic t_busy_ignore();
    set_keys(32'hCAFE_0001, 0);
    run_block(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 10, '1, "R3 start while busy");
  endtask

  task automatic t_hold();
    logic [127:0] held;
    bit ok = 1;
    held = out_block;
    repeat (5) begin
      @(negedge clk);
      if (out_valid || out_block !== held) ok = 0;
    end
    chk(ok, "R10 single pulse and hold", out_block, held);
  endtask

  task automatic t_back_to_back();
    set_keys(32'h5EED_0042, 0);
    run_block(128'hFFFF_0000_FFFF_0000_1234_5678_9ABC_DEF0, -1, '0, "R11 first");
    run_block(128'h0BAD_F00D_0000_0001_8000_0000_7777_7777, -1, '0, "R11 second");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    set_keys(32'h0, 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_patterns();
    t_hold();
    t_word_order();
    t_busy_ignore();
    t_hold();
    @(negedge clk);
    t_back_to_back();
    summary();
  end
endmodule